// File: doc/BRIEF.md
# Dual-Domain Interrupt Aggregation Controller

This block gathers up to 49 single-cycle interrupt events from a display subsystem into sticky status bits. The bits are held in two 32-bit banks. A per-bit steering register sends each source's events to one of two domains, the system domain or the user domain. Each domain has its own enable, preset, clear and status registers. Software sets a status bit through preset, removes it through clear, and reads it back through status.

Each implemented source has its own output line, driven from the user domain. Each domain also has one aggregate line for a parent interrupt controller. Software reaches the registers through a plain 32-bit word port. Reads are combinational and writes take effect in a single cycle.

Source 35 and sources 49 to 63 are holes. Their bits are tied off in every register. The block has no state machine. Its sequencing is one register update per clock, and the decode stage classifies each access into a named register kind.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset every steering, enable and status bit is 0, and all outputs are low.
- R2: A one-cycle pulse on `src_evt[k]` sets bit k%32 of bank k/32. It sets the user status bit when the steering bit is 1 and the system status bit when it is 0. The status bit is visible from the next cycle and stays set until it is cleared.
- R3: Source 35 and bank 1 bits 17 to 31 read as zero in every register and never assert any output, whatever is written or pulsed.
- R4: Word addresses for bank n (0 or 1) are as follows. Steering is at 0x08+4n. System enable, preset, clear and status are at 0x10+4n, 0x18+4n, 0x20+4n and 0x28+4n. User enable, preset, clear and status are at 0x40+4n, 0x48+4n, 0x50+4n and 0x58+4n. Steering and both enables read back what was written. Preset and clear read as zero. Undecoded or unaligned addresses read zero and writes to them do nothing.
- R5: Writes to either status register have no effect.
- R6: Writing 1 to a bit of a clear register clears that status bit in that domain. Bits written as 0 keep their value.
- R7: Writing 1 to a bit of a preset register sets that status bit in that domain.
- R8: When an event or preset and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `src_irq[k]` is high exactly while user status bit k and user enable bit k are both 1.
- R10: `sys_irq` and `usr_irq` are each the OR, over both banks, of that domain's status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 49 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_irq | output | 49 | Per-source gated user-domain lines |
| sys_irq | output | 1 | System domain aggregate |
| usr_irq | output | 1 | User domain aggregate |

## Verification
A source event and a software clear can land on the same status bit in one cycle. The bench provokes this by driving the event pulse and the clear write on the same falling edge, in both domains. It clears a second, already-set bit in the same write. The result is judged one cycle later through the status register: the bit hit by the event must remain set, and the other bit must be gone.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int BANK_W = 32;

    // Register kind, taken from byte address bits [6:3]; bit 2 selects the bank.
    typedef enum logic [3:0] {
        K_NONE  = 4'd0,
        K_STEER = 4'd1,
        K_SEN   = 4'd2,
        K_SPRE  = 4'd3,
        K_SCLR  = 4'd4,
        K_SSTAT = 4'd5,
        K_UEN   = 4'd8,
        K_UPRE  = 4'd9,
        K_UCLR  = 4'd10,
        K_USTAT = 4'd11
    } reg_kind_e;

    function automatic logic [BANK_W-1:0] bank_valid(int bank, int nsrc, int rsvd);
        logic [BANK_W-1:0] v;
        for (int j = 0; j < BANK_W; j++) begin
            v[j] = ((bank * BANK_W + j) < nsrc) && ((bank * BANK_W + j) != rsvd);
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic [AW-1:0] addr,
    output reg_kind_e     kind,
    output logic          bank
);

    logic [3:0] grp;

    always_comb begin
        grp  = addr[6:3];
        bank = addr[2];
        kind = K_NONE;
        if (addr[1:0] == 2'b00 && addr[AW-1:7] == '0) begin
            unique case (grp)
                4'd1:    kind = K_STEER;
                4'd2:    kind = K_SEN;
                4'd3:    kind = K_SPRE;
                4'd4:    kind = K_SCLR;
                4'd5:    kind = K_SSTAT;
                4'd8:    kind = K_UEN;
                4'd9:    kind = K_UPRE;
                4'd10:   kind = K_UCLR;
                4'd11:   kind = K_USTAT;
                default: kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
    import irq_agg_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] evt,
    input  logic              wr,
    input  reg_kind_e         kind,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] steer,
    output logic [BANK_W-1:0] sys_en,
    output logic [BANK_W-1:0] usr_en,
    output logic [BANK_W-1:0] sys_stat,
    output logic [BANK_W-1:0] usr_stat
);

    logic [BANK_W-1:0] sys_set, usr_set, sys_clr, usr_clr;
    logic [BANK_W-1:0] sys_next, usr_next;

    always_comb begin
        sys_set  = (evt & ~steer) & VALID;
        usr_set  = (evt & steer) & VALID;
        sys_clr  = '0;
        usr_clr  = '0;
        if (wr) begin
            unique case (kind)
                K_SPRE:  sys_set = sys_set | (wdata & VALID);
                K_UPRE:  usr_set = usr_set | (wdata & VALID);
                K_SCLR:  sys_clr = wdata;
                K_UCLR:  usr_clr = wdata;
                default: ;
            endcase
        end
        // set has priority over clear so no event is lost
        sys_next = ((sys_stat & ~sys_clr) | sys_set) & VALID;
        usr_next = ((usr_stat & ~usr_clr) | usr_set) & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steer    <= '0;
            sys_en   <= '0;
            usr_en   <= '0;
            sys_stat <= '0;
            usr_stat <= '0;
        end else begin
            if (wr && kind == K_STEER) steer  <= wdata & VALID;
            if (wr && kind == K_SEN)   sys_en <= wdata & VALID;
            if (wr && kind == K_UEN)   usr_en <= wdata & VALID;
            sys_stat <= sys_next;
            usr_stat <= usr_next;
        end
    end

    // R6
    sys_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == K_SCLR) |=> (sys_stat & $past(wdata & ~sys_set)) == '0);

    // R6
    usr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == K_UCLR) |=> (usr_stat & $past(wdata & ~usr_set)) == '0);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sys_set | usr_set) != '0) |=>
            ((sys_stat & $past(sys_set)) == $past(sys_set)) &&
            ((usr_stat & $past(usr_set)) == $past(usr_set)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && evt == '0) |=> ($stable(sys_stat) && $stable(usr_stat)));

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC  = 49,
    parameter int RSVD_SRC = 35,
    parameter int AW       = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [BANK_W-1:0]  wdata,
    output logic [BANK_W-1:0]  rdata,
    output logic [NUM_SRC-1:0] src_irq,
    output logic               sys_irq,
    output logic               usr_irq
);

    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int TOT       = NUM_BANKS * BANK_W;
    localparam int PAD       = TOT - NUM_SRC;

    reg_kind_e kind;
    logic      bank_sel;

    logic [TOT-1:0]    src_pad;
    logic [TOT-1:0]    usr_pend_all, sys_pend_all;
    logic [BANK_W-1:0] steer_q  [NUM_BANKS];
    logic [BANK_W-1:0] sen_q    [NUM_BANKS];
    logic [BANK_W-1:0] uen_q    [NUM_BANKS];
    logic [BANK_W-1:0] sstat_q  [NUM_BANKS];
    logic [BANK_W-1:0] ustat_q  [NUM_BANKS];

    irq_agg_decode #(.AW(AW)) u_dec (
        .addr (addr),
        .kind (kind),
        .bank (bank_sel)
    );

    generate
        if (PAD > 0) begin : g_pad
            assign src_pad = {{PAD{1'b0}}, src_evt};
        end else begin : g_nopad
            assign src_pad = src_evt;
        end

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            irq_agg_bank #(.VALID(bank_valid(b, NUM_SRC, RSVD_SRC))) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (src_pad[b*BANK_W +: BANK_W]),
                .wr       (wr_en && (int'(bank_sel) == b)),
                .kind     (kind),
                .wdata    (wdata),
                .steer    (steer_q[b]),
                .sys_en   (sen_q[b]),
                .usr_en   (uen_q[b]),
                .sys_stat (sstat_q[b]),
                .usr_stat (ustat_q[b])
            );
            assign usr_pend_all[b*BANK_W +: BANK_W] = ustat_q[b] & uen_q[b];
            assign sys_pend_all[b*BANK_W +: BANK_W] = sstat_q[b] & sen_q[b];
        end
    endgenerate

    always_comb begin
        unique case (kind)
            K_STEER: rdata = steer_q[bank_sel];
            K_SEN:   rdata = sen_q[bank_sel];
            K_SSTAT: rdata = sstat_q[bank_sel];
            K_UEN:   rdata = uen_q[bank_sel];
            K_USTAT: rdata = ustat_q[bank_sel];
            default: rdata = '0;
        endcase
    end

    assign src_irq = usr_pend_all[NUM_SRC-1:0];
    assign sys_irq = |sys_pend_all;
    assign usr_irq = |usr_pend_all;

    // R10
    usr_agg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_irq == (src_irq != '0));

    // R3
    hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_irq[RSVD_SRC]);

endmodule

// File: tb/tb_irq_agg_ctrl.sv
`timescale 1ns/1ps
module tb_irq_agg_ctrl;

    localparam int NS = 49;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NS-1:0] src_evt = '0;
    logic          wr_en = 0;
    logic [6:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NS-1:0] src_irq;
    logic          sys_irq, usr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [6:0] A_STEER = 7'h08, A_SEN = 7'h10, A_SPRE = 7'h18,
                           A_SCLR = 7'h20, A_SSTAT = 7'h28, A_UEN = 7'h40,
                           A_UPRE = 7'h48, A_UCLR = 7'h50, A_USTAT = 7'h58;

    always #2.5 clk = ~clk;

    irq_agg_ctrl dut (
        .clk (clk), .rst_n (rst_n), .src_evt (src_evt), .wr_en (wr_en),
        .addr (addr), .wdata (wdata), .rdata (rdata), .src_irq (src_irq),
        .sys_irq (sys_irq), .usr_irq (usr_irq)
    );

    function automatic logic [31:0] vmask(int b);
        logic [31:0] m;
        for (int j = 0; j < 32; j++) m[j] = ((b*32 + j) < NS) && ((b*32 + j) != 35);
        return m;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = '0;
    endtask

    task automatic rd(string req, logic [6:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, {32'd0, rdata}, {32'd0, exp});
    endtask

    task automatic pulse(logic [NS-1:0] v);
        @(negedge clk);
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic clear_all;
        for (int b = 0; b < 2; b++) begin
            wr(A_SCLR + 7'(4*b), '1);
            wr(A_UCLR + 7'(4*b), '1);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1;
        chk("R1 src_irq", 64'(src_irq), 64'd0);
        chk("R1 aggregates", {62'd0, sys_irq, usr_irq}, 64'd0);
        for (int b = 0; b < 2; b++) begin
            rd("R1 steer", A_STEER + 7'(4*b), 32'd0);
            rd("R1 sys en", A_SEN + 7'(4*b), 32'd0);
            rd("R1 usr en", A_UEN + 7'(4*b), 32'd0);
            rd("R1 sys stat", A_SSTAT + 7'(4*b), 32'd0);
            rd("R1 usr stat", A_USTAT + 7'(4*b), 32'd0);
        end

        // R4 readback, R3 holes masked
        for (int b = 0; b < 2; b++) begin
            wr(A_STEER + 7'(4*b), '1);
            wr(A_SEN + 7'(4*b), '1);
            wr(A_UEN + 7'(4*b), '1);
            rd("R4 R3 steer", A_STEER + 7'(4*b), vmask(b));
            rd("R4 R3 sys en", A_SEN + 7'(4*b), vmask(b));
            rd("R4 R3 usr en", A_UEN + 7'(4*b), vmask(b));
            rd("R4 sys preset reads 0", A_SPRE + 7'(4*b), 32'd0);
            rd("R4 usr clear reads 0", A_UCLR + 7'(4*b), 32'd0);
        end
        wr(7'h09, 32'h0);
        rd("R4 unaligned write ignored", A_STEER, vmask(0));
        rd("R4 undecoded reads 0", 7'h30, 32'd0);

        // R5 status writes ignored
        for (int b = 0; b < 2; b++) begin
            wr(A_SSTAT + 7'(4*b), '1);
            wr(A_USTAT + 7'(4*b), '1);
            rd("R5 sys stat", A_SSTAT + 7'(4*b), 32'd0);
            rd("R5 usr stat", A_USTAT + 7'(4*b), 32'd0);
        end
        #1;
        chk("R5 no output", 64'(src_irq), 64'd0);

        // R2 R9 R10 user-domain sweep (steer all 1, user enables all 1)
        for (int k = 0; k < 64; k++) begin
            logic ok;
            logic [63:0] one;
            ok  = (k < NS) && (k != 35);
            one = 64'd1 << k;
            if (k < NS) pulse(NS'(one));
            else        pulse('0);
            #1;
            chk($sformatf("R9 R3 src_irq k=%0d", k), 64'(src_irq), ok ? one : 64'd0);
            chk($sformatf("R10 usr_irq k=%0d", k), {63'd0, usr_irq}, {63'd0, ok});
            chk($sformatf("R2 sys_irq k=%0d", k), {63'd0, sys_irq}, 64'd0);
            rd($sformatf("R2 usr stat k=%0d", k), A_USTAT + 7'(4*(k/32)),
               ok ? (32'd1 << (k%32)) : 32'd0);
            wr(A_UCLR + 7'(4*(k/32)), 32'd1 << (k%32));
            #1;
            chk($sformatf("R6 cleared k=%0d", k), 64'(src_irq), 64'd0);
        end

        // R2 R10 system-domain sweep
        wr(A_STEER, 32'd0);
        wr(A_STEER + 7'd4, 32'd0);
        for (int k = 0; k < NS; k++) begin
            logic ok;
            ok = (k != 35);
            pulse(NS'(64'd1 << k));
            #1;
            chk($sformatf("R10 sys_irq k=%0d", k), {63'd0, sys_irq}, {63'd0, ok});
            chk($sformatf("R2 src_irq quiet k=%0d", k), 64'(src_irq), 64'd0);
            rd($sformatf("R2 sys stat k=%0d", k), A_SSTAT + 7'(4*(k/32)),
               ok ? (32'd1 << (k%32)) : 32'd0);
            wr(A_SCLR + 7'(4*(k/32)), 32'd1 << (k%32));
        end

        // R2 mixed steering within one bank
        wr(A_STEER, 32'h0000FFFF);
        pulse(NS'(64'h0001_0001));
        rd("R2 mixed usr", A_USTAT, 32'h0000_0001);
        rd("R2 mixed sys", A_SSTAT, 32'h0001_0000);
        clear_all();

        // R7 preset, R6 partial clear
        wr(A_UPRE, 32'h0000_0005);
        #1;
        chk("R7 usr preset", 64'(src_irq), 64'h5);
        wr(A_SPRE + 7'd4, '1);
        rd("R7 R3 sys preset bank1", A_SSTAT + 7'd4, vmask(1));
        #1;
        chk("R10 sys_irq after preset", {63'd0, sys_irq}, 64'd1);
        wr(A_UCLR, 32'h0000_0004);
        #1;
        chk("R6 zero bits keep", 64'(src_irq), 64'h1);
        wr(A_SCLR + 7'd4, 32'h0000_0100);
        rd("R6 partial sys clear", A_SSTAT + 7'd4, vmask(1) & ~32'h100);
        clear_all();
        rd("R6 all clear", A_SSTAT + 7'd4, 32'd0);

        // R9 enable gating
        wr(A_UEN, 32'd0);
        wr(A_UPRE, 32'h8);
        #1;
        chk("R9 gated off", 64'(src_irq), 64'd0);
        chk("R10 usr_irq gated", {63'd0, usr_irq}, 64'd0);
        rd("R9 status kept", A_USTAT, 32'h8);
        wr(A_UEN, 32'h8);
        #1;
        chk("R9 gated on", 64'(src_irq), 64'h8);
        clear_all();

        // R8 event vs clear in the same cycle, both domains
        wr(A_STEER, 32'h0000_00FF);
        wr(A_UPRE, 32'h0000_0280);
        wr(A_SPRE, 32'h0000_0200);
        @(negedge clk);
        src_evt = NS'(64'h80);
        wr_en = 1; addr = A_UCLR; wdata = 32'h0000_0280;
        @(negedge clk);
        src_evt = '0; wr_en = 0;
        rd("R8 usr event wins", A_USTAT, 32'h0000_0080);
        @(negedge clk);
        src_evt = NS'(64'h200);
        wr_en = 1; addr = A_SCLR; wdata = 32'h0000_0200;
        @(negedge clk);
        src_evt = '0; wr_en = 0;
        rd("R8 sys event wins", A_SSTAT, 32'h0000_0200);
        @(negedge clk);
        wr_en = 1; addr = A_UPRE; wdata = 32'h1;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        wr_en = 1; addr = A_UCLR; wdata = 32'h81;
        @(negedge clk);
        wr_en = 0;
        rd("R6 after R8", A_USTAT, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule